// File: doc/BRIEF.md
# Backlight PWM Generator with Double-Buffered Timing

This block drives one display-backlight dimming pin with a pulse-width-modulated waveform. A clock prescaler divides the input clock into ticks. A period counter runs over a programmable number of ticks. The pin is high from the start of each period until a programmable high-width count of ticks has passed, and low for the rest of the period.

Software sets the prescaler, period and high width through a small word-addressed register file with a single write strobe and a combinational read port. These writes land in shadow copies. The waveform generator uses a separate working set, which is filled from the shadows when software pulses a commit bit. While the output runs, the new set takes over only at the end of the current period, so the pin never shows a truncated or merged cycle. A debug field can switch off the double buffering, so that timing writes act on the generator at once.

Register words (address is the word index):

- word 0: run enable in bit 0
- word 1: commit strobe in bit 0
- word 2: prescale divider in bits 25:16
- word 3: period in bits 11:0 and high width in bits 28:16
- word 4: buffer-bypass field in bits 1:0

Top module: `backlight_pwm`

## Requirements
- R1: After reset every register reads zero and `pwm_o` is low.
- R2: The period counter advances by one every (divider+1) clock cycles, where the divider is bits 25:16 of word 2.
- R3: One output period lasts (period+1) prescaled ticks, where the period is bits 11:0 of word 3.
- R4: The output is high (normal polarity) for the first high-width ticks of every period, where the high width is bits 28:16 of word 3. A new period starts with the output high when the high width is non-zero.
- R5: While bit 0 of word 0 is clear, `pwm_o` is low and both counters are held at zero. Setting it starts a fresh period at once.
- R6: Writes to words 2 and 3 change only the shadow copies. The working values are loaded from the shadows only after bit 0 of word 1 is written to 1 and then written to 0 (the 1-to-0 write is the trigger).
- R7: A commit made while the output runs takes effect at the end of the current period. The rest of that period keeps the old timing.
- R8: A commit made while the output is disabled loads the working values in the same cycle as the trigger write.
- R9: When both bits of word 4 (bits 1:0) are set, a write to word 2 or word 3 updates both the shadow and the working values at the write's clock edge, with no commit.
- R10: A high width of period+1 or more gives a constant high output. A high width of zero gives a constant low output.
- R11: Each register reads back the value last written to its fields, and unused bits read zero. Word indices 5 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock. Also the prescaler input. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the word at `addr_i` |
| addr_i | input | 3 | Word index for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word at `addr_i`, combinational |
| pwm_o | output | 1 | Backlight PWM output, active high |

## Verification
The assertions assume that `addr_i`, `wr_en_i` and `wdata_i` are always known. They also assume that the bypass field changes only by a write, never together with a timing write. The hold-until-boundary property assumes that no bypass is active while a commit is pending. The stimulus keeps to these rules: inputs change only on falling clock edges, the bypass field is driven by single writes, and random traffic keeps dividers, periods and high widths small. That way many period boundaries, commits that straddle them, and high widths above the period all occur within the run.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   // Word indices of the register file; the decoder compares them against
   // the address port after resizing to the configured address width.
   localparam int unsigned WA_RUN    = 0;
   localparam int unsigned WA_COMMIT = 1;
   localparam int unsigned WA_CLOCK  = 2;
   localparam int unsigned WA_TIMING = 3;
   localparam int unsigned WA_DEBUG  = 4;
   localparam int unsigned WA_COUNT  = 5;

   // Which source updates the working set in a given cycle
   typedef enum logic [1:0] {
      LD_NONE   = 2'd0,
      LD_COMMIT = 2'd1,
      LD_DIRECT = 2'd2
   } load_src_e;

endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
   import dpwm_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned DIV_W      = 10,
   parameter int unsigned DIV_LSB    = 16,
   parameter int unsigned PER_W      = 12,
   parameter int unsigned HI_W       = 13,
   parameter int unsigned HI_LSB     = 16,
   parameter int unsigned DBG_W      = 2,
   parameter bit          BYPASS_OPT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              run_o,
   output logic              commit_fall_o,
   output logic              bypass_o,
   output logic              wr_clock_o,
   output logic              wr_timing_o,
   output logic [DIV_W-1:0]  new_div_o,
   output logic [PER_W-1:0]  new_per_o,
   output logic [HI_W-1:0]   new_hi_o,
   output logic [DIV_W-1:0]  sh_div_o,
   output logic [PER_W-1:0]  sh_per_o,
   output logic [HI_W-1:0]   sh_hi_o
);

   localparam logic [ADDR_W-1:0] A_RUN    = ADDR_W'(WA_RUN);
   localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(WA_COMMIT);
   localparam logic [ADDR_W-1:0] A_CLOCK  = ADDR_W'(WA_CLOCK);
   localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(WA_TIMING);
   localparam logic [ADDR_W-1:0] A_DEBUG  = ADDR_W'(WA_DEBUG);

   logic             run_q;
   logic             cmt_q;
   logic [DIV_W-1:0] div_q;
   logic [PER_W-1:0] per_q;
   logic [HI_W-1:0]  hi_q;
   logic [DBG_W-1:0] dbg_q;

   logic wr_run, wr_cmt, wr_dbg;

   assign wr_run      = wr_en_i && (addr_i == A_RUN);
   assign wr_cmt      = wr_en_i && (addr_i == A_COMMIT);
   assign wr_clock_o  = wr_en_i && (addr_i == A_CLOCK);
   assign wr_timing_o = wr_en_i && (addr_i == A_TIMING);
   assign wr_dbg      = wr_en_i && (addr_i == A_DEBUG);

   // Field slices of the incoming write word
   assign new_div_o = wdata_i[DIV_LSB +: DIV_W];
   assign new_per_o = wdata_i[0 +: PER_W];
   assign new_hi_o  = wdata_i[HI_LSB +: HI_W];

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         cmt_q <= 1'b0;
         div_q <= '0;
         per_q <= '0;
         hi_q  <= '0;
      end else begin
         if (wr_run) run_q <= wdata_i[0];
         if (wr_cmt) cmt_q <= wdata_i[0];
         if (wr_clock_o) div_q <= new_div_o;
         if (wr_timing_o) begin
            per_q <= new_per_o;
            hi_q  <= new_hi_o;
         end
      end
   end

   // The transfer is triggered by the write that clears an armed commit bit
   assign commit_fall_o = wr_cmt && !wdata_i[0] && cmt_q;

   generate
      if (BYPASS_OPT) begin : g_dbg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     dbg_q <= '0;
            else if (wr_dbg) dbg_q <= wdata_i[0 +: DBG_W];
         end
         assign bypass_o = &dbg_q;
      end else begin : g_no_dbg
         logic unused_wr_dbg;
         assign unused_wr_dbg = wr_dbg;
         assign dbg_q    = '0;
         assign bypass_o = 1'b0;
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         A_RUN:    rdata_o[0] = run_q;
         A_COMMIT: rdata_o[0] = cmt_q;
         A_CLOCK:  rdata_o[DIV_LSB +: DIV_W] = div_q;
         A_TIMING: begin
            rdata_o[0 +: PER_W]   = per_q;
            rdata_o[HI_LSB +: HI_W] = hi_q;
         end
         A_DEBUG:  rdata_o[0 +: DBG_W] = dbg_q;
         default:  rdata_o = '0;
      endcase
   end

   assign run_o    = run_q;
   assign sh_div_o = div_q;
   assign sh_per_o = per_q;
   assign sh_hi_o  = hi_q;

endmodule

// File: rtl/dpwm_xfer.sv
module dpwm_xfer
   import dpwm_pkg::*;
#(
   parameter int unsigned DIV_W      = 10,
   parameter int unsigned PER_W      = 12,
   parameter int unsigned HI_W       = 13,
   parameter bit          BYPASS_OPT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             commit_fall_i,
   input  logic             boundary_i,
   input  logic             bypass_i,
   input  logic             wr_clock_i,
   input  logic             wr_timing_i,
   input  logic [DIV_W-1:0] new_div_i,
   input  logic [PER_W-1:0] new_per_i,
   input  logic [HI_W-1:0]  new_hi_i,
   input  logic [DIV_W-1:0] sh_div_i,
   input  logic [PER_W-1:0] sh_per_i,
   input  logic [HI_W-1:0]  sh_hi_i,
   output logic [DIV_W-1:0] wk_div_o,
   output logic [PER_W-1:0] wk_per_o,
   output logic [HI_W-1:0]  wk_hi_o
);

   logic      pend_q;
   logic      want;
   logic      load_now;
   logic      byp_ok;
   load_src_e clk_src, tim_src;

   generate
      if (BYPASS_OPT) begin : g_byp
         assign byp_ok = bypass_i;
      end else begin : g_no_byp
         logic unused_bypass;
         assign unused_bypass = bypass_i;
         assign byp_ok = 1'b0;
      end
   endgenerate

   // A pending commit is released at a period boundary, or at once when idle
   assign want     = pend_q || commit_fall_i;
   assign load_now = want && (!run_i || boundary_i);

   // A direct write in bypass mode wins over a commit in the same cycle
   always_comb begin
      clk_src = LD_NONE;
      tim_src = LD_NONE;
      if (load_now) begin
         clk_src = LD_COMMIT;
         tim_src = LD_COMMIT;
      end
      if (byp_ok && wr_clock_i)  clk_src = LD_DIRECT;
      if (byp_ok && wr_timing_i) tim_src = LD_DIRECT;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wk_div_o <= '0;
         wk_per_o <= '0;
         wk_hi_o  <= '0;
         pend_q   <= 1'b0;
      end else begin
         unique case (clk_src)
            LD_COMMIT: wk_div_o <= sh_div_i;
            LD_DIRECT: wk_div_o <= new_div_i;
            default:   wk_div_o <= wk_div_o;
         endcase
         unique case (tim_src)
            LD_COMMIT: begin
               wk_per_o <= sh_per_i;
               wk_hi_o  <= sh_hi_i;
            end
            LD_DIRECT: begin
               wk_per_o <= new_per_i;
               wk_hi_o  <= new_hi_i;
            end
            default: begin
               wk_per_o <= wk_per_o;
               wk_hi_o  <= wk_hi_o;
            end
         endcase
         pend_q <= want && !load_now;
      end
   end

   AST_HOLD_MID_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni) run_i && !boundary_i && !byp_ok |=> $stable(wk_div_o) && $stable(wk_per_o) && $stable(wk_hi_o)); // R7
   AST_IDLE_COMMIT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) pend_q && !run_i |=> !pend_q); // R8

endmodule

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler #(
   parameter int unsigned DIV_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   // The >= compare makes a divider lowered below the count wrap at once
   assign tick_o = run_i && (cnt_q >= div_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + DIV_W'(1);
   end

endmodule

// File: rtl/dpwm_period.sv
module dpwm_period #(
   parameter int unsigned PER_W = 12,
   parameter int unsigned HI_W  = 13
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [PER_W-1:0] per_i,
   input  logic [HI_W-1:0]  hi_i,
   output logic             boundary_o,
   output logic             pwm_o
);

   logic [PER_W-1:0] cnt_q;

   assign boundary_o = tick_i && (cnt_q >= per_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cnt_q <= '0;
      else if (!run_i)     cnt_q <= '0;
      else if (boundary_o) cnt_q <= '0;
      else if (tick_i)     cnt_q <= cnt_q + PER_W'(1);
   end

   // High while the tick index in the period is below the high width
   assign pwm_o = run_i && (HI_W'(cnt_q) < hi_i);

   AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) !run_i |-> !pwm_o); // R5
   AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(run_i) && (hi_i != '0) |-> pwm_o); // R4
   AST_ZERO_WIDTH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (hi_i == '0) |-> !pwm_o); // R10
   AST_WRAP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni) boundary_o && run_i |=> !boundary_o || (per_i == '0) || $changed(per_i)); // R3

endmodule

// File: rtl/backlight_pwm.sv
module backlight_pwm
   import dpwm_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned DIV_W      = 10,
   parameter int unsigned DIV_LSB    = 16,
   parameter int unsigned PER_W      = 12,
   parameter int unsigned HI_W       = 13,
   parameter int unsigned HI_LSB     = 16,
   parameter int unsigned DBG_W      = 2,
   parameter bit          BYPASS_OPT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              pwm_o
);

   localparam int unsigned WORDS = 1 << ADDR_W;

   // Elaboration-time parameter checks
   generate
      if (DIV_LSB + DIV_W > DATA_W) begin : g_bad_div
         $error("divider field does not fit the data word");
      end
      if (HI_LSB + HI_W > DATA_W) begin : g_bad_hi
         $error("high-width field does not fit the data word");
      end
      if (PER_W > HI_LSB) begin : g_bad_overlap
         $error("period and high-width fields overlap");
      end
      if (HI_W <= PER_W) begin : g_bad_hi_w
         $error("high width must be wider than the period");
      end
      if (WORDS < WA_COUNT) begin : g_bad_addr
         $error("address width too small for the register file");
      end
      if (DBG_W == 0 || DBG_W > DATA_W) begin : g_bad_dbg
         $error("debug field width out of range");
      end
   endgenerate

   logic             run;
   logic             commit_fall;
   logic             bypass;
   logic             wr_clock;
   logic             wr_timing;
   logic             tick;
   logic             boundary;
   logic [DIV_W-1:0] new_div, sh_div, wk_div;
   logic [PER_W-1:0] new_per, sh_per, wk_per;
   logic [HI_W-1:0]  new_hi, sh_hi, wk_hi;

   dpwm_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB),
      .PER_W(PER_W), .HI_W(HI_W), .HI_LSB(HI_LSB), .DBG_W(DBG_W),
      .BYPASS_OPT(BYPASS_OPT)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .run_o(run),
      .commit_fall_o(commit_fall), .bypass_o(bypass),
      .wr_clock_o(wr_clock), .wr_timing_o(wr_timing),
      .new_div_o(new_div), .new_per_o(new_per), .new_hi_o(new_hi),
      .sh_div_o(sh_div), .sh_per_o(sh_per), .sh_hi_o(sh_hi)
   );

   dpwm_xfer #(
      .DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W), .BYPASS_OPT(BYPASS_OPT)
   ) u_xfer (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
      .commit_fall_i(commit_fall), .boundary_i(boundary), .bypass_i(bypass),
      .wr_clock_i(wr_clock), .wr_timing_i(wr_timing),
      .new_div_i(new_div), .new_per_i(new_per), .new_hi_i(new_hi),
      .sh_div_i(sh_div), .sh_per_i(sh_per), .sh_hi_i(sh_hi),
      .wk_div_o(wk_div), .wk_per_o(wk_per), .wk_hi_o(wk_hi)
   );

   dpwm_prescaler #(
      .DIV_W(DIV_W)
   ) u_pre (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(wk_div),
      .tick_o(tick)
   );

   dpwm_period #(
      .PER_W(PER_W), .HI_W(HI_W)
   ) u_period (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(tick),
      .per_i(wk_per), .hi_i(wk_hi), .boundary_o(boundary), .pwm_o(pwm_o)
   );

   AST_RESET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(rst_ni) |-> !pwm_o); // R1
   AST_SHADOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni) !commit_fall && !bypass && run && !boundary |=> $stable(wk_per) && $stable(wk_hi)); // R6

endmodule

// File: tb/sim_backlight_pwm.sv
module sim_backlight_pwm;

   localparam int CLK_PERIOD = 10;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr  = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pwm;

   int    vectors = 0;
   int    miscmp  = 0;
   bit    done    = 1'b0;
   string tag     = "R1";

   backlight_pwm u0 (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Behavioural reference: integer state stepped once per rising edge
   int m_run = 0, m_cm = 0, m_dbg = 0;
   int m_sdiv = 0, m_sper = 0, m_shi = 0;
   int m_wdiv = 0, m_wper = 0, m_whi = 0;
   int m_pend = 0, m_pc = 0, m_cc = 0;

   always @(posedge clk) begin : ref_step
      int tick, wrap, trig, want, load;
      if (!rst_n) begin
         m_run = 0; m_cm = 0; m_dbg = 0;
         m_sdiv = 0; m_sper = 0; m_shi = 0;
         m_wdiv = 0; m_wper = 0; m_whi = 0;
         m_pend = 0; m_pc = 0; m_cc = 0;
      end else begin
         tick = (m_run != 0 && m_pc >= m_wdiv) ? 1 : 0;
         wrap = (tick != 0 && m_cc >= m_wper) ? 1 : 0;
         trig = (wr_en && addr == 3'd1 && !wdata[0] && m_cm != 0) ? 1 : 0;
         want = (m_pend != 0 || trig != 0) ? 1 : 0;
         load = (want != 0 && (m_run == 0 || wrap != 0)) ? 1 : 0;
         if (m_run == 0) begin
            m_pc = 0; m_cc = 0;
         end else if (tick != 0) begin
            m_pc = 0;
            m_cc = (wrap != 0) ? 0 : m_cc + 1;
         end else begin
            m_pc = m_pc + 1;
         end
         if (load != 0) begin
            m_wdiv = m_sdiv; m_wper = m_sper; m_whi = m_shi;
         end
         if (m_dbg == 3 && wr_en && addr == 3'd2)
            m_wdiv = int'((wdata >> 16) & 32'h3FF);
         if (m_dbg == 3 && wr_en && addr == 3'd3) begin
            m_wper = int'(wdata & 32'hFFF);
            m_whi  = int'((wdata >> 16) & 32'h1FFF);
         end
         m_pend = (want != 0 && load == 0) ? 1 : 0;
         if (wr_en) begin
            case (addr)
               3'd0: m_run = int'(wdata[0]);
               3'd1: m_cm  = int'(wdata[0]);
               3'd2: m_sdiv = int'((wdata >> 16) & 32'h3FF);
               3'd3: begin
                  m_sper = int'(wdata & 32'hFFF);
                  m_shi  = int'((wdata >> 16) & 32'h1FFF);
               end
               3'd4: m_dbg = int'(wdata & 32'h3);
               default: ;
            endcase
         end
      end
   end

   // Per-clock comparison of the output against the reference
   always @(negedge clk) begin
      if (!done) begin
         logic exp_pwm;
         exp_pwm = (m_run != 0) && (m_cc < m_whi);
         vectors++;
         if (pwm !== exp_pwm) begin
            miscmp++;
            $display("FAIL %s pwm_o act=%0b exp=%0b at %0t", tag, pwm, exp_pwm, $time);
         end
      end
   end

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscmp++;
         $display("FAIL %s act=%h exp=%h at %0t", t, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string t);
      @(negedge clk);
      wr_en = 1'b0; addr = a;
      #1;
      chk(t, rdata, exp);
   endtask

   task automatic commit();
      wr(3'd1, 32'h1);
      wr(3'd1, 32'h0);
   endtask

   // Counts high cycles; call it right at a falling edge
   task automatic high_cnt(input int n, output int c);
      c = 0;
      repeat (n) begin
         #2;
         if (pwm === 1'b1) c++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscmp++;
         $display("FAIL watchdog act=running exp=finished");
         finish_run();
      end
   end

   initial begin : stimulus
      int c;
      repeat (4) @(negedge clk);
      chk("R1 pwm in reset", {31'b0, pwm}, 32'h0);
      rst_n = 1'b1;

      // R1: reset values
      tag = "R1";
      for (int i = 0; i < 5; i++) rd(3'(i), 32'h0, "R1 reset read");
      chk("R1 pwm after reset", {31'b0, pwm}, 32'h0);

      // R11: readback masks and unmapped words
      tag = "R11";
      wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, 32'h03FF_0000, "R11 clock word");
      wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, 32'h1FFF_0FFF, "R11 timing word");
      wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, 32'h0000_0003, "R11 debug word");
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, 32'h0000_0001, "R11 run word");
      wr(3'd0, 32'h0);
      wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, 32'h0, "R11 word 5");
      wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, 32'h0, "R11 word 7");
      rd(3'd3, 32'h1FFF_0FFF, "R11 timing after unmapped write");
      wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, 32'h0000_0001, "R11 commit word");
      wr(3'd1, 32'h0);
      wr(3'd4, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'h0);
      commit();

      // R6: shadow writes alone leave the output untouched
      tag = "R6";
      wr(3'd0, 32'h1);
      wr(3'd2, 32'h0001_0000);
      wr(3'd3, 32'h0003_0009);
      high_cnt(60, c); chk("R6 no commit, high cycles", c, 0);
      commit();
      repeat (5) @(negedge clk);
      tag = "R2 R3 R4";
      high_cnt(40, c); chk("R2 R3 R4 div1 per9 hi3 high cycles", c, 12);

      // R7: commit while running waits for the period end
      tag = "R7";
      wr(3'd0, 32'h0);
      wr(3'd3, 32'h0007_0009);
      wr(3'd0, 32'h1);
      fork
         commit();
         begin
            int c1, c2;
            high_cnt(20, c1); chk("R7 current period keeps old width", c1, 6);
            high_cnt(20, c2); chk("R7 next period uses new width", c2, 14);
         end
      join

      // R10: wide and zero high widths
      tag = "R10";
      wr(3'd0, 32'h0);
      wr(3'd3, 32'h0014_0009);
      commit();
      wr(3'd0, 32'h1);
      high_cnt(40, c); chk("R10 width above period is constant high", c, 40);
      wr(3'd3, 32'h0000_0009);
      commit();
      repeat (25) @(negedge clk);
      high_cnt(40, c); chk("R10 zero width is constant low", c, 0);

      // R5: disable forces low, re-enable restarts the period
      tag = "R5";
      wr(3'd3, 32'h0003_0009);
      commit();
      repeat (25) @(negedge clk);
      wr(3'd0, 32'h0);
      high_cnt(30, c); chk("R5 disabled output low", c, 0);
      wr(3'd0, 32'h1);
      high_cnt(20, c); chk("R5 restart from period start", c, 6);

      // R8: commit while idle loads at once
      tag = "R8";
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h0003_0000);
      wr(3'd3, 32'h0002_0004);
      commit();
      wr(3'd0, 32'h1);
      high_cnt(20, c); chk("R8 R2 div3 per4 hi2 high cycles", c, 8);

      // R9: bypass mode applies timing writes directly
      tag = "R9";
      wr(3'd4, 32'h3);
      wr(3'd3, 32'h0002_0004);
      wr(3'd2, 32'h0);
      repeat (30) @(negedge clk);
      high_cnt(40, c); chk("R9 direct div0 per4 hi2 high cycles", c, 16);
      rd(3'd3, 32'h0002_0004, "R9 shadow follows direct write");
      wr(3'd4, 32'h0);

      // Mixed random traffic checked cycle by cycle against the reference
      tag = "R6 R7 R9 random";
      for (int k = 0; k < 1500; k++) begin
         logic [2:0]  a;
         logic [31:0] d;
         a = 3'($urandom_range(0, 7));
         case (a)
            3'd0: d = ($urandom_range(0, 3) != 0) ? 32'h1 : 32'h0;
            3'd1: d = 32'($urandom_range(0, 1));
            3'd2: d = 32'($urandom_range(0, 3)) << 16;
            3'd3: d = 32'($urandom_range(0, 15)) | (32'($urandom_range(0, 20)) << 16);
            3'd4: d = 32'($urandom_range(0, 3));
            default: d = $urandom;
         endcase
         wr(a, d);
         repeat ($urandom_range(0, 10)) @(negedge clk);
      end

      finish_run();
   end

endmodule